// File: doc/BRIEF.md
# External Interrupt Sense and Flags

This block is the front end for eight external interrupt pins. Each pin passes through a synchronizer. A per-channel sense mode then watches the pin for one of four conditions: a low level, a falling edge, a rising edge or either edge. When the chosen condition occurs, the channel's status flag is latched. The flag, ANDed with a per-channel enable bit, drives that channel's request output.

Flags clear in three ways:

- **Software:** a handshake on a small register bus. Software must first read the flag as 1, then write 0 to it.
- **Interrupt handler:** per-channel acknowledge pulses.
- **Transfer controller:** per-channel start pulses, each qualified by a keep bit that the controller supplies.

Arbitration between channels and vectoring happen outside the block.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, all flags, the enable register, both sense registers and every request output read 0. Register map: address 0 = flags, 1 = enables, 2 = sense low bit A, 3 = sense high bit B. Bit n of each register belongs to channel n.
- R2: With sense {B,A} = 00 (level), a flag sets while its pin is low. The flag first shows three clock edges after the pin falls, and it stays set after the pin returns high.
- R3: With sense 01, a flag sets on a high-to-low pin change only. A low-to-high change leaves it clear.
- R4: With sense 10, a flag sets on a low-to-high pin change only. A high-to-low change leaves it clear.
- R5: With sense 11, a flag sets on either pin change.
- R6: Writing 1 to a flag bit leaves that flag unchanged. Writing 0 without a prior read of that flag as 1 also leaves it unchanged.
- R7: A read of address 0 that returns a channel's flag as 1 arms that channel. The next write to address 0 then clears every armed flag written as 0. That write disarms all channels, whatever the value written.
- R8: In level mode, an acknowledge pulse clears the flag only when the synchronized pin is high. While the pin is low, the flag stays set.
- R9: In any edge mode, an acknowledge pulse clears the flag unconditionally.
- R10: A transfer start pulse clears the channel's flag when its keep bit is 0. When the keep bit is 1, the flag is left set.
- R11: When a set condition and a clear condition reach a channel in the same cycle, the flag ends set.
- R12: Request output n is high exactly when flag n and enable bit n are both 1. It follows a change of the enable register with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | N_CH | Asynchronous interrupt pins, idle high |
| irq_ack | input | N_CH | Handler acknowledge pulses, one per channel |
| xfer_start | input | N_CH | Transfer-controller start pulses, one per channel |
| xfer_keep | input | N_CH | Per-channel keep bit qualifying xfer_start |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq_req | output | N_CH | Per-channel interrupt request |

## Verification
The hardest situation to create is a set event and a clear event reaching one channel in the same clock edge. The pin path has a fixed three-edge latency, so the bench gets there by timing alone. It drops the pin, waits two falling clock edges, and then raises the acknowledge for exactly the cycle in which the detector fires. The arm-and-consume rule is also reached only in order. The bench makes a read, a write of ones, and a bare write of zero before the real clear. It observes each step through the request output, so that no extra read disturbs the arm state.

// File: rtl/irq_front_pkg.sv
`timescale 1ns/1ps
package irq_front_pkg;

   // Sense encoding {B,A}
   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_FALL = 2'b01,
      SNS_RISE = 2'b10,
      SNS_BOTH = 2'b11
   } sense_e;

   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_SNA  = 2'd2;
   localparam logic [ADDR_W-1:0] ADDR_SNB  = 2'd3;

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irq_chan.sv
`timescale 1ns/1ps
module irq_chan
   import irq_front_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_s,      // synchronized pin
   input  logic [1:0] sense,      // {B,A}
   input  logic       ack,
   input  logic       xfer_go,
   input  logic       xfer_keep,
   input  logic       rd_flag,    // read of flag register this cycle
   input  logic       wr_flag,    // write of flag register this cycle
   input  logic       wr_bit,     // written value for this channel
   output logic       flag,
   output logic       set_ev
);

   logic prev_q;
   logic arm_q;
   logic edge_mode;
   logic clr_sw;
   logic clr_ack;
   logic clr_xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pin_s;
   end

   always_comb begin
      unique case (sense_e'(sense))
         SNS_LOW:  set_ev = ~pin_s;
         SNS_FALL: set_ev = prev_q & ~pin_s;
         SNS_RISE: set_ev = ~prev_q & pin_s;
         SNS_BOTH: set_ev = prev_q ^ pin_s;
         default:  set_ev = 1'b0;
      endcase
   end

   assign edge_mode = (sense_e'(sense) != SNS_LOW);
   assign clr_sw    = wr_flag & ~wr_bit & arm_q;
   assign clr_ack   = ack & (edge_mode | pin_s);
   assign clr_xfer  = xfer_go & ~xfer_keep;

   // set takes precedence over any clear source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= set_ev | (flag & ~(clr_sw | clr_ack | clr_xfer));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              arm_q <= 1'b0;
      else if (wr_flag)        arm_q <= 1'b0;
      else if (rd_flag & flag) arm_q <= 1'b1;
   end

endmodule

// File: rtl/ext_irq_front.sv
`timescale 1ns/1ps
module ext_irq_front
   import irq_front_pkg::*;
#(
   parameter int unsigned N_CH        = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   irq_pin,
   input  logic [N_CH-1:0]   irq_ack,
   input  logic [N_CH-1:0]   xfer_start,
   input  logic [N_CH-1:0]   xfer_keep,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq_req
);

   if (N_CH < 1 || N_CH > DATA_W) begin : g_bad_nch
      $error("ext_irq_front: N_CH must be between 1 and DATA_W");
   end

   logic [N_CH-1:0] pin_s;
   logic [N_CH-1:0] flag_q;
   logic [N_CH-1:0] set_ev;
   logic [N_CH-1:0] en_q;
   logic [N_CH-1:0] sna_q;
   logic [N_CH-1:0] snb_q;
   logic [N_CH-1:0] wdata_ch;
   logic            rd_flag;
   logic            wr_flag;

   assign wdata_ch = bus_wdata[N_CH-1:0];
   assign rd_flag  = bus_sel & ~bus_wr & (bus_addr == ADDR_FLAG);
   assign wr_flag  = bus_sel &  bus_wr & (bus_addr == ADDR_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sna_q <= '0;
         snb_q <= '0;
      end else if (bus_sel && bus_wr) begin
         unique case (bus_addr)
            ADDR_EN:  en_q  <= wdata_ch;
            ADDR_SNA: sna_q <= wdata_ch;
            ADDR_SNB: snb_q <= wdata_ch;
            default:  ;
         endcase
      end
   end

   for (genvar n = 0; n < N_CH; n++) begin : g_ch
      irq_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (1'b1)
      ) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (irq_pin[n]),
         .q     (pin_s[n])
      );

      irq_chan i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[n]),
         .sense     ({snb_q[n], sna_q[n]}),
         .ack       (irq_ack[n]),
         .xfer_go   (xfer_start[n]),
         .xfer_keep (xfer_keep[n]),
         .rd_flag   (rd_flag),
         .wr_flag   (wr_flag),
         .wr_bit    (wdata_ch[n]),
         .flag      (flag_q[n]),
         .set_ev    (set_ev[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_FLAG: bus_rdata[N_CH-1:0] = flag_q;
         ADDR_EN:   bus_rdata[N_CH-1:0] = en_q;
         ADDR_SNA:  bus_rdata[N_CH-1:0] = sna_q;
         ADDR_SNB:  bus_rdata[N_CH-1:0] = snb_q;
         default:   bus_rdata = '0;
      endcase
   end

   assign irq_req = flag_q & en_q;

endmodule

// File: rtl/irq_front_chk.sv
`timescale 1ns/1ps
module irq_front_chk #(
   parameter int unsigned N_CH = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] flag,
   input logic [N_CH-1:0] set_ev,
   input logic [N_CH-1:0] irq_ack,
   input logic [N_CH-1:0] xfer_start,
   input logic [N_CH-1:0] xfer_keep,
   input logic            wr_flag,
   input logic [N_CH-1:0] wdata,
   input logic [N_CH-1:0] irq_req
);

   // R2: with no clear source active, no flag drops
   a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_flag && irq_ack == '0 && xfer_start == '0)
      |=> (($past(flag) & ~flag) == '0));

   // R6: a bit written as 1 keeps its flag
   a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && irq_ack == '0 && xfer_start == '0)
      |=> (($past(flag & wdata) & ~flag) == '0));

   // R10: a transfer start with keep set does not clear
   a_r10_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_flag && irq_ack == '0)
      |=> (($past(flag & xfer_start & xfer_keep) & ~flag) == '0));

   // R11: a detected event always leaves the flag set
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev != '0) |=> (($past(set_ev) & ~flag) == '0));

   // R12: no request without its flag
   a_r12_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~flag) == '0);

endmodule

bind ext_irq_front irq_front_chk #(.N_CH(N_CH)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag       (flag_q),
   .set_ev     (set_ev),
   .irq_ack    (irq_ack),
   .xfer_start (xfer_start),
   .xfer_keep  (xfer_keep),
   .wr_flag    (wr_flag),
   .wdata      (wdata_ch),
   .irq_req    (irq_req)
);

// File: tb/test_ext_irq_front.sv
`timescale 1ns/1ps
module test_ext_irq_front;

   localparam int N_CH   = 8;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_CH-1:0]   irq_pin = '1;
   logic [N_CH-1:0]   irq_ack = '0;
   logic [N_CH-1:0]   xfer_start = '0;
   logic [N_CH-1:0]   xfer_keep = '0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [1:0]        bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [N_CH-1:0]   irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ext_irq_front #(.N_CH(N_CH), .DATA_W(DATA_W)) i_ext_irq_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_pin    (irq_pin),
      .irq_ack    (irq_ack),
      .xfer_start (xfer_start),
      .xfer_keep  (xfer_keep),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_req    (irq_req)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      tick(1);
      bus_sel = 1'b0;
   endtask

   task automatic set_sense(input logic [7:0] a, input logic [7:0] b);
      bus_write(2'd2, a);
      bus_write(2'd3, b);
   endtask

   task automatic clear_all();
      logic [7:0] d;
      bus_read(2'd0, d);
      bus_write(2'd0, 8'h00);
   endtask

   task automatic pulse_ack(input int ch);
      irq_ack[ch] = 1'b1; tick(1); irq_ack[ch] = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 req after reset", irq_req, 0);
      for (int a = 0; a < 4; a++) begin
         bus_read(a[1:0], d);
         chk("R1 register after reset", d, 0);
      end
   endtask

   task automatic t_level();
      set_sense(8'h00, 8'h00);
      irq_pin[0] = 1'b0;
      tick(2);
      chk("R2 level not yet visible", irq_req[0], 0);
      tick(1);
      chk("R2 level sets flag", irq_req[0], 1);
      irq_pin[0] = 1'b1;
      tick(4);
      chk("R2 flag latched after release", irq_req[0], 1);
      clear_all();
      chk("R2 cleared", irq_req, 0);
   endtask

   task automatic t_fall();
      set_sense(8'h02, 8'h00);
      irq_pin[1] = 1'b0; tick(3);
      chk("R3 falling sets", irq_req[1], 1);
      clear_all();
      irq_pin[1] = 1'b1; tick(4);
      chk("R3 rising ignored", irq_req[1], 0);
   endtask

   task automatic t_rise();
      set_sense(8'h00, 8'h04);
      irq_pin[2] = 1'b0; tick(4);
      chk("R4 falling ignored", irq_req[2], 0);
      irq_pin[2] = 1'b1; tick(3);
      chk("R4 rising sets", irq_req[2], 1);
      clear_all();
   endtask

   task automatic t_both();
      set_sense(8'h08, 8'h08);
      irq_pin[3] = 1'b0; tick(3);
      chk("R5 falling sets", irq_req[3], 1);
      clear_all();
      chk("R5 cleared", irq_req[3], 0);
      irq_pin[3] = 1'b1; tick(3);
      chk("R5 rising sets", irq_req[3], 1);
      clear_all();
   endtask

   task automatic t_sw_clear();
      logic [7:0] d;
      set_sense(8'h10, 8'h00);
      irq_pin[4] = 1'b0; tick(3);
      irq_pin[4] = 1'b1;
      bus_write(2'd0, 8'h00);
      chk("R6 write 0 without read keeps", irq_req[4], 1);
      bus_read(2'd0, d);
      chk("R7 read shows flag", d[4], 1);
      bus_write(2'd0, 8'hFF);
      chk("R6 write 1 keeps", irq_req[4], 1);
      bus_write(2'd0, 8'h00);
      chk("R7 arm consumed by prior write", irq_req[4], 1);
      bus_read(2'd0, d);
      bus_write(2'd0, 8'h00);
      chk("R7 read 1 then write 0 clears", irq_req[4], 0);
   endtask

   task automatic t_ack_level();
      set_sense(8'h00, 8'h00);
      irq_pin[5] = 1'b0; tick(3);
      pulse_ack(5);
      chk("R8 ack with pin low keeps", irq_req[5], 1);
      irq_pin[5] = 1'b1; tick(3);
      chk("R8 still set after release", irq_req[5], 1);
      pulse_ack(5);
      chk("R8 ack with pin high clears", irq_req[5], 0);
   endtask

   task automatic t_ack_edge();
      set_sense(8'h40, 8'h00);
      irq_pin[6] = 1'b0; tick(3);
      chk("R9 edge set", irq_req[6], 1);
      pulse_ack(6);
      chk("R9 ack clears with pin low", irq_req[6], 0);
      irq_pin[6] = 1'b1; tick(3);
   endtask

   task automatic t_xfer();
      set_sense(8'h80, 8'h00);
      irq_pin[7] = 1'b0; tick(3);
      xfer_keep[7] = 1'b1; xfer_start[7] = 1'b1; tick(1); xfer_start[7] = 1'b0;
      chk("R10 keep=1 leaves flag", irq_req[7], 1);
      xfer_keep[7] = 1'b0; xfer_start[7] = 1'b1; tick(1); xfer_start[7] = 1'b0;
      chk("R10 keep=0 clears flag", irq_req[7], 0);
      irq_pin[7] = 1'b1; tick(3);
   endtask

   task automatic t_set_wins();
      set_sense(8'h01, 8'h00);
      irq_pin[0] = 1'b0; tick(3);
      chk("R11 first event set", irq_req[0], 1);
      irq_pin[0] = 1'b1; tick(3);
      irq_pin[0] = 1'b0; tick(2);
      irq_ack[0] = 1'b1; tick(1); irq_ack[0] = 1'b0;
      chk("R11 set beats coincident ack", irq_req[0], 1);
      pulse_ack(0);
      chk("R11 lone ack clears", irq_req[0], 0);
      irq_pin[0] = 1'b1; tick(3);
   endtask

   task automatic t_req_mask();
      logic [7:0] d;
      set_sense(8'h00, 8'h00);
      bus_write(2'd1, 8'h00);
      irq_pin[1] = 1'b0; tick(3);
      chk("R12 masked request", irq_req, 0);
      bus_read(2'd0, d);
      chk("R12 flag set under mask", d, 8'h02);
      bus_write(2'd1, 8'h02);
      chk("R12 enable opens request", irq_req, 8'h02);
      irq_pin[1] = 1'b1; tick(3);
      pulse_ack(1);
      chk("R12 request drops with flag", irq_req, 0);
      bus_write(2'd1, 8'hFF);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      bus_write(2'd1, 8'hFF);
      t_level();
      t_fall();
      t_rise();
      t_both();
      t_sw_clear();
      t_ack_level();
      t_ack_edge();
      t_xfer();
      t_set_wins();
      t_req_mask();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule